// File: doc/BRIEF.md
# Timer and Event Counter

This block holds an 8-bit count register that a processor core can run in one of two ways. In timer mode a 5-bit prescaler counts instruction-cycle strobes and advances the register once every 32 of them. In event mode the register advances once for each high-to-low transition on an external test pin. The test pin passes through a two-flop synchronizer before the edge detector. The core starts and stops the block with single-cycle command pulses. It can overwrite the register at any time, and it reads the live value back.

When the register wraps from all ones to zero, a sticky overflow flag is set and an interrupt becomes pending. The interrupt request is the pending bit qualified by an enable bit, which the core sets and clears. Preloading 0xFF therefore makes the very next increment overflow. This is how the core arranges an interrupt on the first external event. Instruction decoding and interrupt vectoring are outside the block.

Top module: `tmr_evt_unit`

## Requirements
- R1: After reset the block is stopped, `count_value` is 0x00, and `ovf_flag`, `irq_req` and the interrupt enable are all 0.
- R2: In timer mode the register increments exactly once per 32 cycles with `tick` high, counted from the last start-timer command. Ticks have no effect in stopped or event mode.
- R3: A start-timer command clears the prescaler to zero and leaves the count register unchanged.
- R4: In event mode the register increments once for each falling edge of `evt_pin` after a two-flop synchronizer, and rising edges have no effect. A falling edge on the pin shows in `count_value` three clock edges later, and the register advances by at most one per clock.
- R5: A stop command freezes the register. It then changes only by a write.
- R6: A write with `wr_en` loads `wr_data` in any mode. If a write and an increment fall in the same cycle, the written value wins.
- R7: An increment from 0xFF gives 0x00 and sets `ovf_flag`. The flag stays set until `flag_clr` is pulsed, and a wrap in the same cycle as `flag_clr` leaves it set.
- R8: Every wrap sets an interrupt-pending bit, whether or not the interrupt is enabled. `irq_ack` clears that bit, but a wrap in the same cycle wins. `irq_req` is high exactly when the bit is pending and the enable is set. `irq_en_set` sets the enable and `irq_en_clr` clears it, with clear winning when both are pulsed.
- R9: When commands coincide, stop wins over start-counter, and start-counter wins over start-timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Instruction-cycle strobe |
| evt_pin | input | 1 | External event test input (asynchronous) |
| cmd_start_timer | input | 1 | Start timer mode, clear prescaler |
| cmd_start_count | input | 1 | Start event-counter mode |
| cmd_stop | input | 1 | Stop counting |
| wr_en | input | 1 | Load the count register |
| wr_data | input | 8 | Value to load |
| irq_en_set | input | 1 | Enable the overflow interrupt |
| irq_en_clr | input | 1 | Disable the overflow interrupt |
| flag_clr | input | 1 | Clear the sticky overflow flag |
| irq_ack | input | 1 | Acknowledge (clear) the pending interrupt |
| count_value | output | 8 | Count register readback |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The assertions watch several properties on every cycle: the write-over-increment priority, wrap to zero, the single-step limit on the register, and that a stopped block holds its value. They also check that start-timer zeroes the prescaler, that the flag stays set, that an acknowledge drops the request, and that stop dominates the other commands. Other behaviour needs whole scenarios, so only the bench scenarios can show it. That covers the 32-tick period, the three-edge latency of pin events, rising edges being ignored, and a pending interrupt surfacing when the enable is set later. Random preload values and tick counts compare the final register and flag against a closed-form bench function.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;

    typedef enum logic [1:0] {
        MODE_STOP  = 2'd0,
        MODE_TIMER = 2'd1,
        MODE_EVENT = 2'd2
    } run_mode_e;

    localparam int CNT_W_DEF  = 8;
    localparam int PRE_W_DEF  = 5;
    localparam int SYNC_N_DEF = 2;

endpackage

// File: rtl/tmr_evt_edge.sv
module tmr_evt_edge #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);
    localparam int SH_W = SYNC_N + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[SH_W-2:0], pin};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // delayed copy high, newest synchronized sample low
    assign fall = st_q.sh[SH_W-1] & ~st_q.sh[SH_W-2];

    // R4: two falling detections cannot be back to back
    a_r4_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/tmr_evt_prescale.sv
module tmr_evt_prescale #(
    parameter int PRE_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic carry
);
    localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.pre = '0;
        end else if (run && tick) begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign carry = run && tick && !clr && (st_q.pre == PRE_MAX);

    // R3: a start-timer clear leaves the prescaler at zero
    a_r3_pre_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.pre == '0));

    // R2: prescaler holds while not running
    a_r2_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(st_q.pre));

endmodule

// File: rtl/tmr_evt_count.sv
module tmr_evt_count #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cnt = wr_data;
        end else if (inc) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign wrap  = inc && !wr_en && (st_q.cnt == CNT_MAX);

    // R6: write wins over any increment
    a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (count == $past(wr_data)));

    // R7: a wrap lands on zero
    a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == '0));

    // R4: without a write the register moves by at most one step
    a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((count == $past(count)) || (count == $past(count) + 1'b1)));

endmodule

// File: rtl/tmr_evt_ctrl.sv
module tmr_evt_ctrl
    import tmr_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_start_timer,
    input  logic      cmd_start_count,
    input  logic      cmd_stop,
    input  logic      irq_en_set,
    input  logic      irq_en_clr,
    input  logic      flag_clr,
    input  logic      irq_ack,
    input  logic      wrap,
    output run_mode_e mode,
    output logic      ovf_flag,
    output logic      irq_req
);
    typedef struct packed {
        run_mode_e mode;
        logic      en;
        logic      flag;
        logic      pend;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // command priority: stop, then counter, then timer
        if (cmd_stop) begin
            st_d.mode = MODE_STOP;
        end else if (cmd_start_count) begin
            st_d.mode = MODE_EVENT;
        end else if (cmd_start_timer) begin
            st_d.mode = MODE_TIMER;
        end

        if (irq_en_clr) begin
            st_d.en = 1'b0;
        end else if (irq_en_set) begin
            st_d.en = 1'b1;
        end

        if (wrap) begin
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end

        if (wrap) begin
            st_d.pend = 1'b1;
        end else if (irq_ack) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MODE_STOP;
            st_q.en   <= 1'b0;
            st_q.flag <= 1'b0;
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode     = st_q.mode;
    assign ovf_flag = st_q.flag;
    assign irq_req  = st_q.pend & st_q.en;

    // R7: flag is sticky until cleared
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    // R8: acknowledge without a new wrap drops the request
    a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !wrap) |=> !irq_req);

    // R8: disabling masks the request
    a_r8_disable_masks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en_clr |=> !irq_req);

    // R9: stop dominates other commands
    a_r9_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop |=> (mode == MODE_STOP));

endmodule

// File: rtl/tmr_evt_unit.sv
module tmr_evt_unit
    import tmr_evt_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int PRE_W  = PRE_W_DEF,
    parameter int SYNC_N = SYNC_N_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             evt_pin,
    input  logic             cmd_start_timer,
    input  logic             cmd_start_count,
    input  logic             cmd_stop,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             irq_en_set,
    input  logic             irq_en_clr,
    input  logic             flag_clr,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] count_value,
    output logic             ovf_flag,
    output logic             irq_req
);
    run_mode_e mode;
    logic      pin_fall;
    logic      pre_carry;
    logic      cnt_inc;
    logic      cnt_wrap;

    tmr_evt_edge #(.SYNC_N(SYNC_N)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (evt_pin),
        .fall  (pin_fall)
    );

    tmr_evt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cmd_start_timer),
        .run   (mode == MODE_TIMER),
        .tick  (tick),
        .carry (pre_carry)
    );

    always_comb begin
        unique case (mode)
            MODE_TIMER: cnt_inc = pre_carry;
            MODE_EVENT: cnt_inc = pin_fall;
            default:    cnt_inc = 1'b0;
        endcase
    end

    tmr_evt_count #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (cnt_inc),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .count   (count_value),
        .wrap    (cnt_wrap)
    );

    tmr_evt_ctrl u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .cmd_start_timer (cmd_start_timer),
        .cmd_start_count (cmd_start_count),
        .cmd_stop        (cmd_stop),
        .irq_en_set      (irq_en_set),
        .irq_en_clr      (irq_en_clr),
        .flag_clr        (flag_clr),
        .irq_ack         (irq_ack),
        .wrap            (cnt_wrap),
        .mode            (mode),
        .ovf_flag        (ovf_flag),
        .irq_req         (irq_req)
    );

    // R5: a stopped block holds its register unless written
    a_r5_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_STOP) && !wr_en) |=> $stable(count_value));

    // R7: the flag follows every wrap
    a_r7_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wrap |=> ovf_flag);

endmodule

// File: tb/tmr_evt_unit_test.sv
module tmr_evt_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       evt_pin = 1'b1;
    logic       cmd_start_timer = 1'b0;
    logic       cmd_start_count = 1'b0;
    logic       cmd_stop = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq_en_set = 1'b0;
    logic       irq_en_clr = 1'b0;
    logic       flag_clr = 1'b0;
    logic       irq_ack = 1'b0;
    logic [7:0] count_value;
    logic       ovf_flag;
    logic       irq_req;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    tmr_evt_unit uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick            (tick),
        .evt_pin         (evt_pin),
        .cmd_start_timer (cmd_start_timer),
        .cmd_start_count (cmd_start_count),
        .cmd_stop        (cmd_stop),
        .wr_en           (wr_en),
        .wr_data         (wr_data),
        .irq_en_set      (irq_en_set),
        .irq_en_clr      (irq_en_clr),
        .flag_clr        (flag_clr),
        .irq_ack         (irq_ack),
        .count_value     (count_value),
        .ovf_flag        (ovf_flag),
        .irq_req         (irq_req)
    );

    function automatic logic [7:0] exp_timer_cnt(input logic [7:0] v, input int n);
        return 8'((int'(v) + n / 32) % 256);
    endfunction

    function automatic logic exp_timer_ovf(input logic [7:0] v, input int n);
        return (int'(v) + n / 32) > 255;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic do_write(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start_timer();
        cmd_start_timer = 1'b1; @(negedge clk); cmd_start_timer = 1'b0;
    endtask

    task automatic start_count();
        cmd_start_count = 1'b1; @(negedge clk); cmd_start_count = 1'b0;
    endtask

    task automatic stop();
        cmd_stop = 1'b1; @(negedge clk); cmd_stop = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    endtask

    // one falling then rising pin edge, each level held long enough to settle
    task automatic pin_pulse();
        evt_pin = 1'b0; idle(4);
        evt_pin = 1'b1; idle(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 count", count_value, 0);
        check("R1 flag", ovf_flag, 0);
        check("R1 irq", irq_req, 0);

        // R2 ticks while stopped do nothing
        ticks(40);
        check("R2 stopped ticks", count_value, 0);

        // R6 write while stopped
        do_write(8'h10);
        check("R6 load", count_value, 8'h10);

        // R2 period of 32
        start_timer();
        ticks(31);
        check("R2 after 31 ticks", count_value, 8'h10);
        ticks(1);
        check("R2 after 32 ticks", count_value, 8'h11);

        // R3 restart clears prescaler, keeps register
        ticks(16);
        start_timer();
        check("R3 register kept", count_value, 8'h11);
        ticks(16);
        check("R3 prescaler cleared", count_value, 8'h11);
        ticks(16);
        check("R3 next step", count_value, 8'h12);

        // R5 stop freezes
        stop();
        ticks(64);
        pin_pulse();
        check("R5 frozen", count_value, 8'h12);

        // R4 R7 R8 event mode, preload all ones
        do_write(8'hFF);
        irq_en_set = 1'b1; @(negedge clk); irq_en_set = 1'b0;
        start_count();
        evt_pin = 1'b0;
        idle(2);
        check("R4 latency not yet", count_value, 8'hFF);
        idle(1);
        check("R4 first event wraps", count_value, 8'h00);
        check("R7 flag set", ovf_flag, 1);
        check("R8 irq raised", irq_req, 1);
        idle(2);
        evt_pin = 1'b1; idle(6);
        check("R4 rising ignored", count_value, 8'h00);

        ack();
        check("R8 ack clears irq", irq_req, 0);
        check("R7 flag survives ack", ovf_flag, 1);
        clear_flag();
        check("R7 flag cleared", ovf_flag, 0);

        for (int i = 0; i < 5; i++) pin_pulse();
        check("R4 five events", count_value, 8'h05);
        ticks(40);
        check("R2 ticks ignored in event mode", count_value, 8'h05);

        // R6 write beats an increment in the same cycle
        stop();
        do_write(8'h40);
        start_timer();
        ticks(31);
        wr_en = 1'b1; wr_data = 8'h80; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        check("R6 write wins", count_value, 8'h80);

        // R7 wrap beats flag clear; R8 pending while disabled
        stop();
        irq_en_clr = 1'b1; @(negedge clk); irq_en_clr = 1'b0;
        do_write(8'hFF);
        start_timer();
        ticks(31);
        flag_clr = 1'b1; tick = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0; tick = 1'b0;
        check("R7 wrap count", count_value, 8'h00);
        check("R7 wrap beats clear", ovf_flag, 1);
        check("R8 masked", irq_req, 0);
        irq_en_set = 1'b1; @(negedge clk); irq_en_set = 1'b0;
        check("R8 pending surfaces", irq_req, 1);
        irq_en_set = 1'b1; irq_en_clr = 1'b1; @(negedge clk);
        irq_en_set = 1'b0; irq_en_clr = 1'b0;
        check("R8 clear wins over set", irq_req, 0);
        irq_en_set = 1'b1; @(negedge clk); irq_en_set = 1'b0;
        ack();
        check("R8 ack while enabled", irq_req, 0);

        // R9 command priority
        stop();
        do_write(8'h20);
        cmd_stop = 1'b1; cmd_start_timer = 1'b1; @(negedge clk);
        cmd_stop = 1'b0; cmd_start_timer = 1'b0;
        ticks(40);
        pin_pulse();
        check("R9 stop wins", count_value, 8'h20);
        cmd_start_count = 1'b1; cmd_start_timer = 1'b1; @(negedge clk);
        cmd_start_count = 1'b0; cmd_start_timer = 1'b0;
        ticks(40);
        check("R9 counter wins, ticks ignored", count_value, 8'h20);
        pin_pulse();
        check("R9 counter wins, event counted", count_value, 8'h21);

        // R2 R7 random preload and tick counts
        for (int k = 0; k < 20; k++) begin
            logic [7:0] v;
            int n;
            v = 8'($urandom_range(0, 255));
            n = int'($urandom_range(0, 300));
            if (k == 0) begin v = 8'hFF; n = 32; end
            stop();
            clear_flag();
            do_write(v);
            start_timer();
            ticks(n);
            stop();
            check("R2 random count", count_value, exp_timer_cnt(v, n));
            check("R7 random flag", ovf_flag, exp_timer_ovf(v, n));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule